// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-Down Sequencer

This block sits beside the command scheduler of an SDRAM controller. It decides when to drop the memory clock-enable (CKE) while the device is idle. When new work arrives it also decides when the command bus may carry real commands again. Power-down is allowed only while a 2-bit low-power mode field holds the power-down code. Entry follows a selectable idle timeout. Exit is triggered by an access request or a refresh request, or by the mode field leaving the power-down code.

The memory performs no refresh of its own while CKE is low. For that reason, a pending refresh request wakes the device, and the refresh engine gets its grant only once the bus is usable. The exit sequence depends on the device family. A programmable minimum CKE-low time applies to the low-power DDR and DDR2 families. During the whole exit window the scheduler's commands are overridden with NOP.

Top module: `pd_cke_ctrl`

## Requirements
- R1: Power-down is entered only while `lp_mode` equals 2'b10. With any other code CKE stays high. If the code changes away from 2'b10 while CKE is low, the block exits exactly as it does for a wake request.
- R2: A cycle is idle when `dev_busy`, `acc_req` and `ref_req` are all low. With `idle_sel` 2'b00 (and 2'b11, which behaves the same way) CKE is low in the cycle after the first idle cycle. With 2'b01 CKE is low from the 64th cycle after the first idle cycle, and with 2'b10 from the 128th.
- R3: Any non-idle cycle restarts the idle count from zero.
- R4: While CKE is low, `force_nop` is 1 and `bus_rdy` is 0.
- R5: A wake request (`acc_req` or `ref_req` high, or the mode left) seen while CKE is low raises CKE. It then opens an exit window in which `force_nop` is 1 and `bus_rdy` is 0.
- R6: For `dev_kind` 2'b00 (SDR), 2'b01 (low-power SDR) and 2'b11 (DDR2) the exit window lasts one cycle. `bus_rdy` returns in the next cycle.
- R7: For `dev_kind` 2'b10 (low-power DDR) the exit window lasts max(`t_xp`,1) cycles.
- R8: For `dev_kind` 2'b10 and 2'b11, CKE stays low for at least max(`t_cke`,1) cycles. A wake request arriving earlier is held until that count is met. For 2'b00 and 2'b01 a wake request seen in a low cycle raises CKE in the next cycle.
- R9: `ref_grant` equals `ref_req` while `bus_rdy` is 1, and is 0 otherwise.
- R10: After reset, `cke`=1, `bus_rdy`=1, `force_nop`=0 and `ref_grant`=0.
- R11: Once the access or refresh has finished and the device is idle again, power-down is re-entered by the rule of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_mode | input | 2 | Low-power mode field; 2'b10 allows power-down |
| idle_sel | input | 2 | Idle timeout select: 00/11 immediate, 01 64 cycles, 10 128 cycles |
| dev_kind | input | 2 | Device family: 00 SDR, 01 LP-SDR, 10 LP-DDR, 11 DDR2 |
| t_xp | input | 4 | Exit NOP count for LP-DDR |
| t_cke | input | 4 | Minimum CKE-low cycles for LP-DDR and DDR2 |
| dev_busy | input | 1 | Device selected or access in progress |
| acc_req | input | 1 | Scheduler has an access waiting |
| ref_req | input | 1 | Refresh engine requests a refresh |
| cke | output | 1 | Clock enable to the memory |
| force_nop | output | 1 | Override the command bus with NOP |
| bus_rdy | output | 1 | Command bus may carry scheduler commands |
| ref_grant | output | 1 | Refresh may proceed |

## Verification
The assertions assume that `dev_kind`, `t_cke` and `t_xp` change only while the bus is ready. The checks on exit length and minimum CKE-low time read these inputs at the moment CKE rises, so they must hold the values that governed the sequence. In the random phase, the stimulus changes configuration only after it has forced the block awake with an access request and seen `bus_rdy`. It keeps that request high through the change, so no entry can begin with a half-applied setting. The request pulses are kept sparse so that idle runs long enough to reach power-down occur often.

// File: rtl/pd_cke_pkg.sv
package pd_cke_pkg;

    typedef enum logic [1:0] {
        PD_ON   = 2'd0,
        PD_LOW  = 2'd1,
        PD_WAKE = 2'd2
    } pd_state_e;

    localparam logic [1:0] LP_CODE_PD  = 2'b10;
    localparam logic [1:0] KIND_LPDDR  = 2'b10;
    localparam logic [1:0] SEL_SHORT   = 2'b01;
    localparam logic [1:0] SEL_LONG    = 2'b10;

    typedef struct packed {
        pd_state_e st;
    } pd_regs_t;

endpackage

// File: rtl/pd_dwell_cnt.sv
// Counts consecutive cycles in which run is high; clears when run drops.
module pd_dwell_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = '0;
        if (run) begin
            cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pd_idle_timer.sv
// Idle run counter with selectable expiry point.
module pd_idle_timer
    import pd_cke_pkg::*;
#(
    parameter int IDLE_SHORT = 64,
    parameter int IDLE_LONG  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       armed,
    input  logic       quiet,
    input  logic [1:0] sel,
    output logic       expire
);
    localparam int CNT_W = $clog2(IDLE_LONG + 1);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(IDLE_SHORT);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(IDLE_LONG);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;
    logic             counting;

    always_comb begin
        unique case (sel)
            SEL_SHORT: limit = SHORT_V;
            SEL_LONG:  limit = LONG_V;
            default:   limit = '0;
        endcase
        counting = armed && quiet;
        expire   = counting && ((limit == '0) || (cnt_q >= limit - 1'b1));
        cnt_d    = '0;
        if (counting) begin
            cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !quiet |=> (cnt_q == '0));
endmodule

// File: rtl/pd_cke_ctrl.sv
module pd_cke_ctrl
    import pd_cke_pkg::*;
#(
    parameter int TIME_W     = 4,
    parameter int IDLE_SHORT = 64,
    parameter int IDLE_LONG  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lp_mode,
    input  logic [1:0]        idle_sel,
    input  logic [1:0]        dev_kind,
    input  logic [TIME_W-1:0] t_xp,
    input  logic [TIME_W-1:0] t_cke,
    input  logic              dev_busy,
    input  logic              acc_req,
    input  logic              ref_req,
    output logic              cke,
    output logic              force_nop,
    output logic              bus_rdy,
    output logic              ref_grant
);
    localparam int DWELL_W = TIME_W + 1;
    localparam int CMP_W   = DWELL_W + 1;

    pd_regs_t r_d, r_q;

    logic               quiet, mode_on, wake_src, need_res;
    logic               idle_expire, res_ok, wake_done;
    logic [DWELL_W-1:0] res_cnt, wake_cnt;
    logic [CMP_W-1:0]   res_len, wake_len, res_span, wake_span;

    always_comb begin
        quiet    = !dev_busy && !acc_req && !ref_req;
        mode_on  = (lp_mode == LP_CODE_PD);
        wake_src = acc_req || ref_req || !mode_on;
        need_res = dev_kind[1];
    end

    pd_idle_timer #(
        .IDLE_SHORT (IDLE_SHORT),
        .IDLE_LONG  (IDLE_LONG)
    ) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed  (mode_on && (r_q.st == PD_ON)),
        .quiet  (quiet),
        .sel    (idle_sel),
        .expire (idle_expire)
    );

    pd_dwell_cnt #(.W(DWELL_W)) u_res_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st == PD_LOW),
        .cnt_q (res_cnt)
    );

    pd_dwell_cnt #(.W(DWELL_W)) u_wake_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st == PD_WAKE),
        .cnt_q (wake_cnt)
    );

    always_comb begin
        res_len  = (t_cke == '0) ? CMP_W'(1) : CMP_W'(t_cke);
        wake_len = CMP_W'(1);
        if (dev_kind == KIND_LPDDR && t_xp != '0) begin
            wake_len = CMP_W'(t_xp);
        end
        res_span  = CMP_W'(res_cnt) + 1'b1;
        wake_span = CMP_W'(wake_cnt) + 1'b1;
        res_ok    = !need_res || (res_span >= res_len);
        wake_done = (wake_span >= wake_len);
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            PD_ON: begin
                if (idle_expire) r_d.st = PD_LOW;
            end
            PD_LOW: begin
                if (wake_src && res_ok) r_d.st = PD_WAKE;
            end
            PD_WAKE: begin
                if (wake_done) r_d.st = PD_ON;
            end
            default: r_d.st = PD_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PD_ON};
        else        r_q <= r_d;
    end

    always_comb begin
        cke       = (r_q.st != PD_LOW);
        force_nop = (r_q.st != PD_ON);
        bus_rdy   = (r_q.st == PD_ON);
        ref_grant = bus_rdy && ref_req;
    end

    // Checker support: length of the current CKE-low run.
    logic [CMP_W-1:0] low_run_d, low_run_q;
    always_comb begin
        low_run_d = '0;
        if (!cke) low_run_d = (low_run_q == {CMP_W{1'b1}}) ? low_run_q : low_run_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_run_q <= '0;
        else        low_run_q <= low_run_d;
    end

    // R4
    low_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (force_nop && !bus_rdy));

    // R1
    entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> ($past(lp_mode) == 2'b10));

    // R9
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_grant |-> (bus_rdy && cke && ref_req));

    // R5
    wake_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (force_nop && !bus_rdy));

    // R6
    short_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cke) && dev_kind != 2'b10) |=> bus_rdy);

    // R8
    min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cke) && dev_kind[1]) |-> (low_run_q >= res_len));
endmodule

// File: tb/pd_cke_ctrl_bench.sv
module pd_cke_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] lp = 2'b00, sel = 2'b00, kind = 2'b00;
    logic [3:0] txp = 4'd1, tcke = 4'd1;
    logic       busy = 1'b0, acc = 1'b0, rf = 1'b0;
    logic       cke, nop, rdy, gnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state: 0 on, 1 low, 2 exit window
    int ms = 0, idle_n = 0, low_n = 0, wake_n = 0;

    always #5 clk = ~clk;

    pd_cke_ctrl u_pd_cke_ctrl (
        .clk(clk), .rst_n(rst_n), .lp_mode(lp), .idle_sel(sel), .dev_kind(kind),
        .t_xp(txp), .t_cke(tcke), .dev_busy(busy), .acc_req(acc), .ref_req(rf),
        .cke(cke), .force_nop(nop), .bus_rdy(rdy), .ref_grant(gnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int idle_limit(input logic [1:0] s);
        if (s == 2'b01) return 64;
        if (s == 2'b10) return 128;
        return 0;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic model_step();
        bit quiet_c = !busy && !acc && !rf;
        bit wake_c  = acc || rf || (lp != 2'b10);
        int lim;
        if (ms == 0) begin
            if (lp == 2'b10 && quiet_c) begin
                lim = idle_limit(sel);
                if (lim == 0 || idle_n >= lim - 1) begin
                    ms = 1; idle_n = 0; low_n = 0;
                end else idle_n++;
            end else idle_n = 0;
        end else if (ms == 1) begin
            if (wake_c && (!kind[1] || low_n + 1 >= at_least_one(int'(tcke)))) begin
                ms = 2; wake_n = 0;
            end else low_n++;
        end else begin
            lim = (kind == 2'b10) ? at_least_one(int'(txp)) : 1;
            if (wake_n + 1 >= lim) begin
                ms = 0; idle_n = 0;
            end else wake_n++;
        end
    endtask

    task automatic compare_model();
        check("R4 cke vs model", int'(cke), (ms != 1) ? 1 : 0);
        check("R5 bus_rdy vs model", int'(rdy), (ms == 0) ? 1 : 0);
        check("R5 force_nop vs model", int'(nop), (ms != 0) ? 1 : 0);
        check("R9 ref_grant vs model", int'(gnt), (ms == 0 && rf) ? 1 : 0);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        compare_model();
    endtask

    task automatic reconfigure(input logic [1:0] nlp, input logic [1:0] nsel,
                               input logic [1:0] nkind, input logic [3:0] nxp,
                               input logic [3:0] ncke);
        acc = 1'b1;
        for (int k = 0; k < 40 && !rdy; k++) tick();
        tick();
        lp = nlp; sel = nsel; kind = nkind; txp = nxp; tcke = ncke;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit stayed;
        void'($urandom(32'h1d5e_a7c3));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset values
        check("R10 cke", int'(cke), 1);
        check("R10 bus_rdy", int'(rdy), 1);
        check("R10 force_nop", int'(nop), 0);
        check("R10 ref_grant", int'(gnt), 0);
        rst_n = 1'b1;

        // R2: immediate entry with code 00
        lp = 2'b10; sel = 2'b00; kind = 2'b00; busy = 1'b1;
        tick();
        busy = 1'b0;
        tick();
        check("R2 code00 cke low", int'(cke), 0);

        // R5/R6: SDR exit
        acc = 1'b1;
        tick();
        check("R5 cke up", int'(cke), 1);
        check("R5 nop in window", int'(nop), 1);
        check("R5 not ready in window", int'(rdy), 0);
        tick();
        check("R6 ready after one NOP", int'(rdy), 1);

        // R3: restart of the 64-cycle count
        sel = 2'b01; acc = 1'b0;
        repeat (40) tick();
        check("R3 still high after 40", int'(cke), 1);
        busy = 1'b1;
        tick();
        busy = 1'b0;
        repeat (63) tick();
        check("R3 high after 63 idle", int'(cke), 1);
        tick();
        check("R3 low on 64th idle", int'(cke), 0);

        // R2: code 10
        acc = 1'b1;
        tick(); tick();
        sel = 2'b10; acc = 1'b0;
        repeat (127) tick();
        check("R2 code10 high after 127", int'(cke), 1);
        tick();
        check("R2 code10 low on 128th", int'(cke), 0);

        // R7/R8: LP-DDR residency and exit length
        acc = 1'b1;
        tick(); tick();
        kind = 2'b10; txp = 4'd3; tcke = 4'd4; sel = 2'b00; acc = 1'b0;
        tick();
        check("R8 entered", int'(cke), 0);
        acc = 1'b1;
        repeat (3) tick();
        check("R8 held low during minimum", int'(cke), 0);
        tick();
        check("R8 released after minimum", int'(cke), 1);
        repeat (2) tick();
        check("R7 still in exit window", int'(rdy), 0);
        tick();
        check("R7 ready after t_xp", int'(rdy), 1);

        // R8: SDR ignores the minimum
        kind = 2'b00; tcke = 4'd15; txp = 4'd15;
        tick();
        acc = 1'b0;
        tick();
        check("R8 sdr entered", int'(cke), 0);
        acc = 1'b1;
        tick();
        check("R8 sdr exits at once", int'(cke), 1);
        tick();

        // R1: mode gating
        lp = 2'b00; acc = 1'b0;
        stayed = 1'b1;
        for (int k = 0; k < 150; k++) begin
            tick();
            if (!cke) stayed = 1'b0;
        end
        check("R1 no entry outside mode", int'(stayed), 1);
        lp = 2'b10;
        tick();
        check("R1 entry in mode", int'(cke), 0);
        lp = 2'b01;
        tick();
        check("R1 leaving mode wakes", int'(cke), 1);
        tick();
        check("R1 ready after leaving", int'(rdy), 1);

        // R9 / R11: refresh handshake
        lp = 2'b10; rf = 1'b1;
        tick();
        check("R9 grant when ready", int'(gnt), 1);
        rf = 1'b0;
        tick();
        check("R9 entered", int'(cke), 0);
        rf = 1'b1;
        #1;
        check("R9 no grant while low", int'(gnt), 0);
        tick();
        check("R9 no grant in window", int'(gnt), 0);
        tick();
        check("R9 grant after exit", int'(gnt), 1);
        rf = 1'b0;
        tick();
        check("R11 re-entry after refresh", int'(cke), 0);

        // random phase
        for (int blk = 0; blk < 60; blk++) begin
            logic [1:0] nlp;
            logic [1:0] nsel;
            nlp  = ($urandom % 5 == 0) ? 2'($urandom) : 2'b10;
            nsel = ($urandom % 6 == 0) ? 2'b01 : (($urandom % 4 == 0) ? 2'b11 : 2'b00);
            reconfigure(nlp, nsel, 2'($urandom), 4'($urandom), 4'($urandom));
            acc = 1'b0;
            for (int c = 0; c < 70; c++) begin
                busy = ($urandom % 16 == 0);
                acc  = ($urandom % 24 == 0);
                rf   = ($urandom % 40 == 0);
                tick();
            end
            busy = 1'b0; rf = 1'b0;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule